// File: doc/BRIEF.md
# Start/Halt Fetch-Execute Sequencer

This block is the control heart of a 32-bit load/store processor. It owns the run flag, the program counter and the instruction register. It steps through four phases: idle, fetch, load and execute. While halted it waits for a start request. While running it reads the next instruction word from a word-addressed instruction memory, which answers one cycle after the read strobe. It then splits the captured word into its operand and constant fields and offers them to an external execute stage.

The execute stage replies with a done pulse. With that pulse it may also supply a new program counter, for branches and jumps. The block handles two opcodes itself. The no-operation opcode spends one execute cycle and goes straight back to fetch. The halt opcode drops the run flag, and fetching then stops until the next start request.

The register file, the ALU, branch evaluation and data memory all sit outside the block. The block sees them only through the execute handshake.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is high, and after it until a start request arrives, `running` is 0, `pc` is 0 and both `imem_rd` and `exec_valid` are 0.
- R2: If `start` is sampled high while `running` is 0, then `running` is 1 after that edge. In the following cycle `imem_rd` is 1 with `imem_addr` equal to `pc[IMEM_AW+1:2]`.
- R3: `imem_rd` is high for exactly one cycle, with `imem_addr = pc[IMEM_AW+1:2]`. On the edge after the strobe cycle, two things happen together: the instruction register takes `imem_rdata`, and `pc` becomes its old value plus 4.
- R4: In the execute cycle, the fields are taken from the captured word w. These are `f_op` = w[31:27], `f_ra` = w[26:22], `f_rb` = w[21:17] and `f_rc` = w[16:12]. The constants are `f_c1` = w[21:0], `f_c2` = w[16:0] and `f_c3` = w[11:0].
- R5: Opcode 0 (no-operation) takes one execute cycle with `exec_valid` at 0. The next cycle is a fetch.
- R6: Opcode 31 (halt) keeps `exec_valid` at 0 and clears `running` at the end of its execute cycle. After that no `imem_rd` is issued until a new start request. The restart then fetches from the PC that follows the halt word.
- R7: Every other opcode raises `exec_valid` in the cycle after capture. `exec_valid` stays high, with no fetch, until `exec_done` is sampled high. The next cycle is then a fetch.
- R8: If `pc_load` is high together with `exec_done` while `exec_valid` is 1, the next fetch uses `pc_value` as its PC.
- R9: A `start` pulse while `running` is 1 has no effect. The run flag, the phase sequence and the PC carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, honoured only while halted |
| running | output | 1 | Run flag |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_addr | output | IMEM_AW | Instruction memory word address |
| imem_rdata | input | XLEN | Instruction word, valid one cycle after the strobe |
| exec_valid | output | 1 | Decoded instruction offered to the execute stage |
| f_op | output | 5 | Opcode field |
| f_ra | output | 5 | Destination register field |
| f_rb | output | 5 | First source / index register field |
| f_rc | output | 5 | Second source / test / count register field |
| f_c1 | output | 22 | Long displacement field |
| f_c2 | output | 17 | Short displacement / immediate field |
| f_c3 | output | 12 | Count / modifier field |
| pc | output | XLEN | Program counter, already advanced past the current word |
| exec_done | input | 1 | Execute stage finished |
| pc_load | input | 1 | Replace the PC when `exec_done` is high |
| pc_value | input | XLEN | New PC value |

## Verification
A start request sampled at one edge shows a read strobe right after that same edge. The fetched word and the PC advanced by 4 become visible two edges after the strobe cycle begins. `exec_done` is accepted at one edge, and the next strobe, at the old or the jumped PC, is visible right after that edge. A halt drops `running` one edge after its execute cycle. The bench drives every input 1 ns after a rising edge and samples the outputs at that same point. It walks its expected PC through exactly this edge count, so each field, strobe and address comparison lands on the single cycle in which it is due.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_LOAD  = 2'd2,
    PH_EXEC  = 2'd3
  } phase_t;

  localparam int OP_W  = 5;
  localparam int REG_W = 5;
  localparam int C1_W  = 22;
  localparam int C2_W  = 17;
  localparam int C3_W  = 12;
  localparam int WORD_W = 32;

  localparam logic [OP_W-1:0] OPC_NOP  = 5'd0;
  localparam logic [OP_W-1:0] OPC_HALT = 5'd31;
endpackage

// File: rtl/fes_run_flag.sv
module fes_run_flag (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic halt_req,
  output logic run
);
  always_ff @(posedge clk) begin
    if (rst)                run <= 1'b0;
    else if (!run && start) run <= 1'b1;
    else if (halt_req)      run <= 1'b0;
  end

  AST_RUN_SET_BY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(start)); // R2
  AST_RUN_CLEAR_BY_HALT: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(halt_req)); // R6
endmodule

// File: rtl/fes_pc_ir.sv
module fes_pc_ir #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [XLEN-1:0] word_in,
  input  logic            jump,
  input  logic [XLEN-1:0] jump_pc,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] ir
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else if (capture) begin
      ir <= word_in;
      pc <= pc + STEP;
    end else if (jump) begin
      pc <= jump_pc;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(capture) |-> pc == $past(pc) + STEP); // R3
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(capture) |-> $stable(ir)); // R3
  AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
    $past(jump) |-> pc == $past(jump_pc)); // R8
endmodule

// File: rtl/fes_field_split.sv
module fes_field_split
  import fes_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [OP_W-1:0]   op,
  output logic [REG_W-1:0]  ra,
  output logic [REG_W-1:0]  rb,
  output logic [REG_W-1:0]  rc,
  output logic [C1_W-1:0]   c1,
  output logic [C2_W-1:0]   c2,
  output logic [C3_W-1:0]   c3
);
  always_comb begin
    op = word[31:27];
    ra = word[26:22];
    rb = word[21:17];
    rc = word[16:12];
    c1 = word[21:0];
    c2 = word[16:0];
    c3 = word[11:0];
  end
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import fes_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               running,
  output logic               imem_rd,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [XLEN-1:0]    imem_rdata,
  output logic               exec_valid,
  output logic [4:0]         f_op,
  output logic [4:0]         f_ra,
  output logic [4:0]         f_rb,
  output logic [4:0]         f_rc,
  output logic [21:0]        f_c1,
  output logic [16:0]        f_c2,
  output logic [11:0]        f_c3,
  output logic [XLEN-1:0]    pc,
  input  logic               exec_done,
  input  logic               pc_load,
  input  logic [XLEN-1:0]    pc_value
);
  phase_t          phase;
  logic [XLEN-1:0] ir;
  logic            in_exec, is_nop, is_halt, halt_req, capture, jump, accept;

  assign in_exec  = (phase == PH_EXEC);
  assign is_nop   = (f_op == OPC_NOP);
  assign is_halt  = (f_op == OPC_HALT);
  assign halt_req = in_exec && is_halt;
  assign capture  = (phase == PH_LOAD);
  assign accept   = exec_valid && exec_done;
  assign jump     = accept && pc_load;

  assign exec_valid = in_exec && !is_nop && !is_halt;
  assign imem_rd    = (phase == PH_FETCH);
  assign imem_addr  = pc[IMEM_AW+1:2];

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else begin
      unique case (phase)
        PH_IDLE:  if (start) phase <= PH_FETCH;
        PH_FETCH: phase <= PH_LOAD;
        PH_LOAD:  phase <= PH_EXEC;
        PH_EXEC: begin
          if (is_halt)                phase <= PH_IDLE;
          else if (is_nop || accept)  phase <= PH_FETCH;
        end
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  fes_run_flag u_run (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .halt_req (halt_req),
    .run      (running)
  );

  fes_pc_ir #(.XLEN(XLEN)) u_pc_ir (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .word_in (imem_rdata),
    .jump    (jump),
    .jump_pc (pc_value),
    .pc      (pc),
    .ir      (ir)
  );

  fes_field_split u_split (
    .word (ir[WORD_W-1:0]),
    .op   (f_op),
    .ra   (f_ra),
    .rb   (f_rb),
    .rc   (f_rc),
    .c1   (f_c1),
    .c2   (f_c2),
    .c3   (f_c3)
  );

  AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    imem_rd |-> running); // R6
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    imem_rd |=> !imem_rd); // R3
  AST_EXEC_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> !imem_rd); // R7
  AST_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_done) |=> imem_rd); // R7
  AST_NOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (in_exec && is_nop) |=> imem_rd); // R5
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (in_exec && is_halt) |=> (!running && !imem_rd)); // R6
  AST_START_IGNORED_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (running && start && !halt_req) |=> running); // R9
endmodule

// File: tb/fetch_exec_seq_bench.sv
module fetch_exec_seq_bench;
  localparam int XLEN = 32;
  localparam int AW   = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, exec_done, pc_load;
  logic [XLEN-1:0] pc_value, imem_rdata, pc;
  logic running, imem_rd, exec_valid;
  logic [AW-1:0] imem_addr;
  logic [4:0] f_op, f_ra, f_rb, f_rc;
  logic [21:0] f_c1;
  logic [16:0] f_c2;
  logic [11:0] f_c3;

  logic [31:0] mem [0:63];
  int checks = 0;
  int failures = 0;
  logic [31:0] exp_pc;

  fetch_exec_seq #(.XLEN(XLEN), .IMEM_AW(AW)) u_fetch_exec_seq (
    .clk(clk), .rst(rst), .start(start), .running(running),
    .imem_rd(imem_rd), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .exec_valid(exec_valid), .f_op(f_op), .f_ra(f_ra), .f_rb(f_rb),
    .f_rc(f_rc), .f_c1(f_c1), .f_c2(f_c2), .f_c3(f_c3), .pc(pc),
    .exec_done(exec_done), .pc_load(pc_load), .pc_value(pc_value)
  );

  always_ff @(posedge clk) if (imem_rd) imem_rdata <= mem[imem_addr[5:0]];

  function automatic logic [31:0] field(input logic [31:0] w, input int hi, input int lo);
    return (w >> lo) & ((32'h1 << (hi - lo + 1)) - 32'h1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check_fetch(input string req);
    chk(req, 32'(imem_rd), 32'd1);
    chk(req, 32'(imem_addr), 32'(exp_pc[11:2]));
  endtask

  task automatic do_start;
    start = 1'b1;
    tick;
    start = 1'b0;
    chk("R2 running", 32'(running), 32'd1);
    check_fetch("R2");
  endtask

  task automatic idle_quiet(input int n);
    for (int i = 0; i < n; i++) begin
      tick;
      chk("R6 no strobe", 32'(imem_rd), 32'd0);
      chk("R6 halted", 32'(running), 32'd0);
    end
  endtask

  task automatic run_instr(input logic [31:0] w, input bit ld, input logic [31:0] npc,
                           input int dly, input bit poke);
    mem[exp_pc[7:2]] = w;
    check_fetch("R3 fetch");
    tick;
    chk("R3 strobe once", 32'(imem_rd), 32'd0);
    tick;
    chk("R3 pc+4", pc, exp_pc + 32'd4);
    exp_pc = exp_pc + 32'd4;
    chk("R4 op", 32'(f_op), field(w, 31, 27));
    chk("R4 ra", 32'(f_ra), field(w, 26, 22));
    chk("R4 rb", 32'(f_rb), field(w, 21, 17));
    chk("R4 rc", 32'(f_rc), field(w, 16, 12));
    chk("R4 c1", 32'(f_c1), field(w, 21, 0));
    chk("R4 c2", 32'(f_c2), field(w, 16, 0));
    chk("R4 c3", 32'(f_c3), field(w, 11, 0));
    if (w[31:27] == 5'd0) begin
      chk("R5 no exec", 32'(exec_valid), 32'd0);
      tick;
      check_fetch("R5 refetch");
    end else if (w[31:27] == 5'd31) begin
      chk("R6 no exec", 32'(exec_valid), 32'd0);
      tick;
      chk("R6 run clear", 32'(running), 32'd0);
      chk("R6 no strobe", 32'(imem_rd), 32'd0);
    end else begin
      chk("R7 valid", 32'(exec_valid), 32'd1);
      for (int d = 0; d < dly; d++) begin
        if (poke && d == 0) start = 1'b1;
        tick;
        start = 1'b0;
        chk("R7 hold", 32'(exec_valid), 32'd1);
        chk("R7 no fetch", 32'(imem_rd), 32'd0);
        if (poke) chk("R9 still running", 32'(running), 32'd1);
      end
      exec_done = 1'b1;
      pc_load   = ld;
      pc_value  = npc;
      tick;
      exec_done = 1'b0;
      pc_load   = 1'b0;
      pc_value  = 32'hDEAD_BEE0;
      if (ld) begin
        exp_pc = npc;
        check_fetch("R8 jump");
      end else begin
        check_fetch("R7 refetch");
      end
      chk("R7 valid drop", 32'(exec_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst = 1'b1; start = 1'b0; exec_done = 1'b0; pc_load = 1'b0; pc_value = '0;
    exp_pc = 32'h0;
    repeat (3) tick;
    chk("R1 running", 32'(running), 32'd0);
    chk("R1 strobe", 32'(imem_rd), 32'd0);
    chk("R1 exec", 32'(exec_valid), 32'd0);
    chk("R1 pc", pc, 32'd0);
    rst = 1'b0;
    tick;
    chk("R1 stays idle", 32'(imem_rd), 32'd0);
    chk("R1 stays halted", 32'(running), 32'd0);

    do_start;
    run_instr(32'h0000_0000, 1'b0, 32'h0, 0, 1'b0);
    run_instr({5'd12, 27'h51A_BCDE}, 1'b0, 32'h0, 0, 1'b0);
    run_instr({5'd13, 27'h7FF_FFFF}, 1'b0, 32'h0, 2, 1'b1);
    run_instr({5'd8, 27'h123_4567}, 1'b1, 32'h0000_0040, 1, 1'b0);
    run_instr({5'd31, 27'h0}, 1'b0, 32'h0, 0, 1'b0);
    idle_quiet(4);
    do_start;

    for (int n = 0; n < 80; n++) begin
      int r;
      logic [4:0] op;
      logic [31:0] w;
      r = int'($urandom % 20);
      if (r < 3)       op = 5'd0;
      else if (r == 3) op = 5'd31;
      else             op = 5'(1 + ($urandom % 30));
      w = {op, 27'($urandom)};
      run_instr(w, ($urandom % 10) < 3, {24'h0, 6'($urandom), 2'b00},
                int'($urandom % 4), ($urandom % 5) == 0);
      if (op == 5'd31) begin
        idle_quiet(2);
        do_start;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule